// File: doc/BRIEF.md
# Beamforming Training Weight Sequencer

This block drives the per-antenna complex weights of a multi-antenna RF front-end whose signal weighting happens in the analogue domain. During a channel-training frame it walks the front-end through a series of orthogonal weight vectors, one for each OFDM training symbol. The frame carries nT×nR such symbols. The local station acts either as the transmitting side or as the receiving side of the exchange, and it steps its own antennas through the rows that belong to that side. Outside training it supplies either a uniform default vector or a stored set of optimal weights. Applying the same weight to every antenna makes the link behave like a single-antenna one.

Each symbol strobe that the current mode accepts produces one registered weight vector with a one-cycle valid pulse. The vector holds one signed 8-bit I value and one signed 8-bit Q value per antenna, and it is sent to the stage that translates weights for the front-end. Optimal weights are written one antenna at a time. A write that arrives while a training sequence is running is held back and takes effect once that sequence ends.

Top module: `bf_train_seq`

## Requirements
- R1: During synchronous active-low reset, and in the first cycle after it, `w_valid` is 0 and every lane of `w_i` and `w_q` is 0.
- R2: The antenna counts `n_tx`, `n_rx` and the role `is_tx` are captured in the first cycle in which `mode` equals TRAIN (2'b01). A strobe in that cycle is ignored. A count of 0 is treated as 1, and a count above 4 is treated as 4.
- R3: After entering TRAIN, exactly nT×nR strobes each produce a valid vector. `w_valid` is high in the cycle right after the strobe. Further strobes while TRAIN is held produce no valid pulse.
- R4: For training symbol k, counted from 0, the transmit row is k / nR and the receive row is k mod nR. A station with `is_tx`=1 uses the transmit row and nT. A station with `is_tx`=0 uses the receive row and nR.
- R5: In a training vector, antenna a occupies bits [8a+7:8a]. It carries I = +64 (8'h40) when the number of set bits in (row AND a) is even, and I = -64 (8'hC0) when it is odd. Q is 0. Antennas at or above the side's count carry I = Q = 0.
- R6: In mode DATA_DEFAULT (2'b10), every strobe produces I = 8'h40 and Q = 0 on all four antennas.
- R7: In mode DATA_OPT (2'b11), every strobe produces the stored optimal weights. A write with `opt_we` to antenna `opt_ant` outside training replaces that antenna's stored I and Q.
- R8: An optimal-weight write made while a training sequence is active is deferred. It is not lost, and it applies once the sequence ends, either after the last training strobe or when `mode` leaves TRAIN.
- R9: In mode IDLE (2'b00), strobes produce no valid pulse and leave `w_i` and `w_q` unchanged.
- R10: `w_i` and `w_q` change only in a cycle in which `w_valid` is high.
- R11: After reset, the stored optimal weights equal the default vector (I = 8'h40, Q = 0 on every antenna).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 idle, 01 training, 10 data with default weights, 11 data with optimal weights |
| is_tx | input | 1 | Local station is the transmitting side of the training exchange |
| n_tx | input | 3 | Transmit antenna count from the training frame's signal field |
| n_rx | input | 3 | Receive antenna count from the training frame's signal field |
| sym_stb | input | 1 | One-cycle OFDM symbol strobe |
| opt_we | input | 1 | Optimal-weight write enable |
| opt_ant | input | 2 | Antenna index of the optimal-weight write |
| opt_i | input | 8 | Signed I value to store |
| opt_q | input | 8 | Signed Q value to store |
| w_valid | output | 1 | One-cycle pulse marking a new weight vector |
| w_i | output | 32 | I weights, antenna a in bits [8a+7:8a] |
| w_q | output | 32 | Q weights, antenna a in bits [8a+7:8a] |

## Verification
The bench runs complete training frames for both roles and for uneven antenna counts. A design that swapped quotient and remainder, or the role selection, would emit the wrong row order for the 2×3 and 3×2 frames. Counts of 0 and above four check the clamping, since an unclamped count would either sequence zero symbols or run past sixteen. The strobe after the last training symbol must stay silent with the outputs held, which catches an off-by-one in the end-of-frame test. Optimal writes made during training are checked after normal completion and after an aborted frame. A design that dropped the write, or that only committed it a cycle late, would show the old value on the first data strobe.

// File: rtl/bf_pkg.sv
// Shared types for the beamforming training weight sequencer.
// Assumes a 2-bit mode input whose codes match bf_mode_e.
package bf_pkg;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_TRAIN = 2'b01,
        MD_DDEF  = 2'b10,
        MD_DOPT  = 2'b11
    } bf_mode_e;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'b00,
        SRC_TRAIN = 2'b01,
        SRC_DEF   = 2'b10,
        SRC_OPT   = 2'b11
    } bf_src_e;

endpackage

// File: rtl/bf_seq_ctrl.sv
// Mode decoder and training symbol counter.
// Captures the antenna counts and the role on entry into training, walks
// receive rows inside transmit rows, and tells the output stage which
// source to emit on each accepted strobe.
// Assumes sym_stb is a one-cycle pulse.
module bf_seq_ctrl
    import bf_pkg::*;
#(
    parameter int MAX_ANT = 4,
    localparam int CNT_W  = $clog2(MAX_ANT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             is_tx,
    input  logic [CNT_W-1:0] n_tx,
    input  logic [CNT_W-1:0] n_rx,
    input  logic             sym_stb,
    output logic             trn_act,
    output logic             emit,
    output bf_src_e          src,
    output logic [CNT_W-1:0] loc_row,
    output logic [CNT_W-1:0] loc_cnt
);

    bf_mode_e         md;
    bf_mode_e         prev_md;
    logic             act_q;
    logic             role_q;
    logic [CNT_W-1:0] ntx_q;
    logic [CNT_W-1:0] nrx_q;
    logic [CNT_W-1:0] txr_q;
    logic [CNT_W-1:0] rxr_q;
    logic             entry;
    logic             trn_stb;

    // Limit a decoded antenna count to the range 1..MAX_ANT.
    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v);
        if (v == '0) begin
            return CNT_W'(1);
        end
        if (v > CNT_W'(MAX_ANT)) begin
            return CNT_W'(MAX_ANT);
        end
        return v;
    endfunction

    assign md      = bf_mode_e'(mode);
    assign entry   = (md == MD_TRAIN) && (prev_md != MD_TRAIN);
    assign trn_stb = sym_stb && (md == MD_TRAIN) && act_q;

    // Track the previous mode, the captured frame parameters and the row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_md <= MD_IDLE;
            act_q   <= 1'b0;
            role_q  <= 1'b0;
            ntx_q   <= CNT_W'(1);
            nrx_q   <= CNT_W'(1);
            txr_q   <= '0;
            rxr_q   <= '0;
        end else begin
            prev_md <= md;
            if (entry) begin
                act_q  <= 1'b1;
                role_q <= is_tx;
                ntx_q  <= clamp_cnt(n_tx);
                nrx_q  <= clamp_cnt(n_rx);
                txr_q  <= '0;
                rxr_q  <= '0;
            end else if (md != MD_TRAIN) begin
                act_q <= 1'b0;
            end else if (trn_stb) begin
                if (rxr_q == nrx_q - CNT_W'(1)) begin
                    rxr_q <= '0;
                    if (txr_q == ntx_q - CNT_W'(1)) begin
                        act_q <= 1'b0;
                    end else begin
                        txr_q <= txr_q + CNT_W'(1);
                    end
                end else begin
                    rxr_q <= rxr_q + CNT_W'(1);
                end
            end
        end
    end

    // Decide whether a strobe produces a vector and from which source.
    always_comb begin
        emit = 1'b0;
        src  = SRC_HOLD;
        if (sym_stb) begin
            unique case (md)
                MD_TRAIN: begin
                    if (act_q) begin
                        emit = 1'b1;
                        src  = SRC_TRAIN;
                    end
                end
                MD_DDEF: begin
                    emit = 1'b1;
                    src  = SRC_DEF;
                end
                MD_DOPT: begin
                    emit = 1'b1;
                    src  = SRC_OPT;
                end
                default: begin
                    emit = 1'b0;
                    src  = SRC_HOLD;
                end
            endcase
        end
    end

    assign trn_act = act_q;
    assign loc_row = role_q ? txr_q : rxr_q;
    assign loc_cnt = role_q ? ntx_q : nrx_q;

endmodule

// File: rtl/bf_walsh_gen.sv
// Orthogonal training vector generator.
// For a given row and active antenna count, produces a +/-AMP pattern on I
// (Hadamard sign = parity of row AND antenna index) with Q zero; antennas
// beyond the count are zeroed. Purely combinational.
module bf_walsh_gen #(
    parameter int MAX_ANT = 4,
    parameter int W_BITS  = 8,
    parameter int AMP     = 64,
    localparam int CNT_W  = $clog2(MAX_ANT + 1),
    localparam int VEC_W  = MAX_ANT * W_BITS
) (
    input  logic [CNT_W-1:0] row,
    input  logic [CNT_W-1:0] cnt,
    output logic [VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0] vec_q
);

    localparam logic [W_BITS-1:0] POS = W_BITS'(AMP);
    localparam logic [W_BITS-1:0] NEG = W_BITS'(-AMP);

    for (genvar a = 0; a < MAX_ANT; a++) begin : g_lane
        logic neg;
        logic on;
        // Sign and enable of one antenna lane.
        assign neg = ^(row & CNT_W'(a));
        assign on  = CNT_W'(a) < cnt;
        assign vec_i[a*W_BITS +: W_BITS] = on ? (neg ? NEG : POS) : '0;
        assign vec_q[a*W_BITS +: W_BITS] = '0;
    end

endmodule

// File: rtl/bf_opt_store.sv
// Per-antenna optimal weight store with deferred writes.
// While hold is high, writes land in a pending slot per antenna. Once hold
// drops, the pending value is forwarded at once and committed on the next
// edge. A direct write outside hold replaces the pending slot.
module bf_opt_store #(
    parameter int MAX_ANT = 4,
    parameter int W_BITS  = 8,
    parameter int AMP     = 64,
    localparam int IDX_W  = (MAX_ANT > 1) ? $clog2(MAX_ANT) : 1,
    localparam int VEC_W  = MAX_ANT * W_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              we,
    input  logic [IDX_W-1:0]  ant,
    input  logic [W_BITS-1:0] wi,
    input  logic [W_BITS-1:0] wq,
    output logic [VEC_W-1:0]  opt_i,
    output logic [VEC_W-1:0]  opt_q
);

    localparam logic [W_BITS-1:0] POS = W_BITS'(AMP);

    for (genvar a = 0; a < MAX_ANT; a++) begin : g_slot
        logic [W_BITS-1:0] cur_i;
        logic [W_BITS-1:0] cur_q;
        logic [W_BITS-1:0] pnd_i;
        logic [W_BITS-1:0] pnd_q;
        logic              pnd_v;
        logic              hit;

        assign hit = we && (ant == IDX_W'(a));

        // Store, defer or commit the weight of one antenna.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_i <= POS;
                cur_q <= '0;
                pnd_i <= '0;
                pnd_q <= '0;
                pnd_v <= 1'b0;
            end else if (hit && hold) begin
                pnd_i <= wi;
                pnd_q <= wq;
                pnd_v <= 1'b1;
            end else if (hit) begin
                cur_i <= wi;
                cur_q <= wq;
                pnd_v <= 1'b0;
            end else if (pnd_v && !hold) begin
                cur_i <= pnd_i;
                cur_q <= pnd_q;
                pnd_v <= 1'b0;
            end
        end

        assign opt_i[a*W_BITS +: W_BITS] = (pnd_v && !hold) ? pnd_i : cur_i;
        assign opt_q[a*W_BITS +: W_BITS] = (pnd_v && !hold) ? pnd_q : cur_q;
    end

endmodule

// File: rtl/bf_train_seq.sv
// Beamforming training weight sequencer (top).
// Steps the front-end through orthogonal weights per training symbol and
// otherwise delivers default or stored optimal weights. Each accepted
// strobe yields a registered vector one cycle later with a valid pulse.
// Assumes mode is stable around strobes and sym_stb is a single-cycle pulse.
module bf_train_seq
    import bf_pkg::*;
#(
    parameter int MAX_ANT = 4,
    parameter int W_BITS  = 8,
    parameter int AMP     = 64,
    localparam int CNT_W  = $clog2(MAX_ANT + 1),
    localparam int IDX_W  = (MAX_ANT > 1) ? $clog2(MAX_ANT) : 1,
    localparam int VEC_W  = MAX_ANT * W_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              is_tx,
    input  logic [CNT_W-1:0]  n_tx,
    input  logic [CNT_W-1:0]  n_rx,
    input  logic              sym_stb,
    input  logic              opt_we,
    input  logic [IDX_W-1:0]  opt_ant,
    input  logic [W_BITS-1:0] opt_i,
    input  logic [W_BITS-1:0] opt_q,
    output logic              w_valid,
    output logic [VEC_W-1:0]  w_i,
    output logic [VEC_W-1:0]  w_q
);

    localparam logic [VEC_W-1:0] DEF_I = {MAX_ANT{W_BITS'(AMP)}};

    logic             trn_act;
    logic             emit;
    bf_src_e          src;
    logic [CNT_W-1:0] loc_row;
    logic [CNT_W-1:0] loc_cnt;
    logic [VEC_W-1:0] trn_i;
    logic [VEC_W-1:0] trn_q;
    logic [VEC_W-1:0] st_i;
    logic [VEC_W-1:0] st_q;
    logic             vld_q;
    logic [VEC_W-1:0] wi_q;
    logic [VEC_W-1:0] wq_q;

    bf_seq_ctrl #(.MAX_ANT(MAX_ANT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .is_tx   (is_tx),
        .n_tx    (n_tx),
        .n_rx    (n_rx),
        .sym_stb (sym_stb),
        .trn_act (trn_act),
        .emit    (emit),
        .src     (src),
        .loc_row (loc_row),
        .loc_cnt (loc_cnt)
    );

    bf_walsh_gen #(.MAX_ANT(MAX_ANT), .W_BITS(W_BITS), .AMP(AMP)) u_walsh (
        .row   (loc_row),
        .cnt   (loc_cnt),
        .vec_i (trn_i),
        .vec_q (trn_q)
    );

    bf_opt_store #(.MAX_ANT(MAX_ANT), .W_BITS(W_BITS), .AMP(AMP)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (trn_act),
        .we    (opt_we),
        .ant   (opt_ant),
        .wi    (opt_i),
        .wq    (opt_q),
        .opt_i (st_i),
        .opt_q (st_q)
    );

    // Register the selected vector and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            wi_q  <= '0;
            wq_q  <= '0;
        end else begin
            vld_q <= emit;
            if (emit) begin
                unique case (src)
                    SRC_TRAIN: begin
                        wi_q <= trn_i;
                        wq_q <= trn_q;
                    end
                    SRC_DEF: begin
                        wi_q <= DEF_I;
                        wq_q <= '0;
                    end
                    SRC_OPT: begin
                        wi_q <= st_i;
                        wq_q <= st_q;
                    end
                    default: begin
                        wi_q <= wi_q;
                        wq_q <= wq_q;
                    end
                endcase
            end
        end
    end

    assign w_valid = vld_q;
    assign w_i     = wi_q;
    assign w_q     = wq_q;

endmodule

// File: rtl/bf_train_seq_chk.sv
// Port-level checker for bf_train_seq, attached by bind.
// Assumes the mode codes of bf_pkg and a one-cycle output latency.
module bf_train_seq_chk
    import bf_pkg::*;
#(
    parameter int MAX_ANT = 4,
    parameter int W_BITS  = 8,
    parameter int AMP     = 64,
    localparam int VEC_W  = MAX_ANT * W_BITS,
    localparam int SEEN_W = $clog2(MAX_ANT * MAX_ANT + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             sym_stb,
    input logic             w_valid,
    input logic [VEC_W-1:0] w_i,
    input logic [VEC_W-1:0] w_q
);

    localparam logic [VEC_W-1:0] DEF_I = {MAX_ANT{W_BITS'(AMP)}};
    localparam logic [SEEN_W-1:0] SEEN_MAX = {SEEN_W{1'b1}};

    logic [1:0]        pm_q;
    logic [SEEN_W-1:0] seen_q;

    // Remember the mode of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q <= MD_IDLE;
        end else begin
            pm_q <= mode;
        end
    end

    // Count training vectors since the last entry into training.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (mode == MD_TRAIN && pm_q != MD_TRAIN) begin
            seen_q <= '0;
        end else if (w_valid && pm_q == MD_TRAIN && seen_q != SEEN_MAX) begin
            seen_q <= seen_q + SEEN_W'(1);
        end
    end

    AST_VALID_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> $past(sym_stb)); // R3

    AST_TRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= SEEN_W'(MAX_ANT * MAX_ANT)); // R3

    AST_TRAIN_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && pm_q == MD_TRAIN) |-> (w_q == '0)); // R5

    AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && pm_q == MD_DDEF) |-> (w_i == DEF_I && w_q == '0)); // R6

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (pm_q != MD_IDLE)); // R9

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !w_valid |-> ($stable(w_i) && $stable(w_q))); // R10

endmodule

bind bf_train_seq bf_train_seq_chk #(
    .MAX_ANT (MAX_ANT),
    .W_BITS  (W_BITS),
    .AMP     (AMP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .sym_stb (sym_stb),
    .w_valid (w_valid),
    .w_i     (w_i),
    .w_q     (w_q)
);

// File: tb/sim_bf_train_seq.sv
// Bench for bf_train_seq: a table of training frames walked by one loop,
// then directed tests for reset, data modes, idle and deferred writes.
module sim_bf_train_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        is_tx = 1'b0;
    logic [2:0]  n_tx = 3'd1;
    logic [2:0]  n_rx = 3'd1;
    logic        sym_stb = 1'b0;
    logic        opt_we = 1'b0;
    logic [1:0]  opt_ant = 2'd0;
    logic [7:0]  opt_i = 8'd0;
    logic [7:0]  opt_q = 8'd0;
    logic        w_valid;
    logic [31:0] w_i;
    logic [31:0] w_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Frame table: {is_tx, n_tx, n_rx}
    localparam logic [6:0] FRAMES [0:7] = '{
        {1'b0, 3'd4, 3'd4},
        {1'b1, 3'd4, 3'd4},
        {1'b1, 3'd2, 3'd3},
        {1'b0, 3'd3, 3'd2},
        {1'b1, 3'd1, 3'd4},
        {1'b0, 3'd4, 3'd1},
        {1'b1, 3'd0, 3'd2},
        {1'b0, 3'd7, 3'd6}
    };

    bf_train_seq u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .is_tx   (is_tx),
        .n_tx    (n_tx),
        .n_rx    (n_rx),
        .sym_stb (sym_stb),
        .opt_we  (opt_we),
        .opt_ant (opt_ant),
        .opt_i   (opt_i),
        .opt_q   (opt_q),
        .w_valid (w_valid),
        .w_i     (w_i),
        .w_q     (w_q)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clampc(input logic [2:0] v);
        if (v == 3'd0) return 1;
        if (v > 3'd4) return 4;
        return int'(v);
    endfunction

    // Expected training I vector from R2, R4 and R5.
    function automatic logic [31:0] exp_trn(input logic role, input logic [2:0] nt,
                                            input logic [2:0] nr, input int k);
        logic [31:0] r;
        int ct;
        int cr;
        int row;
        int cnt;
        ct  = clampc(nt);
        cr  = clampc(nr);
        row = role ? (k / cr) : (k % cr);
        cnt = role ? ct : cr;
        r = '0;
        for (int a = 0; a < 4; a++) begin
            if (a < cnt) begin
                r[a*8 +: 8] = ($countones(row & a) % 2 == 1) ? 8'hC0 : 8'h40;
            end
        end
        return r;
    endfunction

    // Pulse the strobe for one cycle; return at the sampling point after it.
    task automatic strobe();
        @(negedge clk);
        sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    // Change mode and let the entry cycle pass.
    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    task automatic load_opt(input logic [1:0] a, input logic [7:0] vi, input logic [7:0] vq);
        @(negedge clk);
        opt_we  = 1'b1;
        opt_ant = a;
        opt_i   = vi;
        opt_q   = vq;
        @(negedge clk);
        opt_we  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        // R1: reset state, during reset and in the first cycle after it
        check("R1 valid in reset", {31'd0, w_valid}, 32'd0);
        check("R1 w_i in reset", w_i, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, w_valid}, 32'd0);
        check("R1 w_q after reset", w_q, 32'd0);

        // R11: stored optimal weights start at the default vector
        set_mode(2'b11);
        strobe();
        check("R11 opt valid", {31'd0, w_valid}, 32'd1);
        check("R11 opt I after reset", w_i, 32'h40404040);
        check("R11 opt Q after reset", w_q, 32'd0);
        set_mode(2'b00);

        // Table walk: R2, R3, R4, R5 for each frame
        for (int f = 0; f < 8; f++) begin
            int tot;
            is_tx = FRAMES[f][6];
            n_tx  = FRAMES[f][5:3];
            n_rx  = FRAMES[f][2:0];
            tot   = clampc(FRAMES[f][5:3]) * clampc(FRAMES[f][2:0]);
            set_mode(2'b01);
            for (int k = 0; k < tot; k++) begin
                strobe();
                check("R3 training valid", {31'd0, w_valid}, 32'd1);
                check("R4 R5 training I", w_i, exp_trn(FRAMES[f][6], FRAMES[f][5:3], FRAMES[f][2:0], k));
                check("R5 training Q", w_q, 32'd0);
            end
            held = w_i;
            strobe();
            check("R3 extra strobe silent", {31'd0, w_valid}, 32'd0);
            check("R10 held after frame", w_i, held);
            set_mode(2'b00);
        end

        // R2: strobe in the entry cycle is ignored
        is_tx = 1'b0;
        n_tx  = 3'd1;
        n_rx  = 3'd2;
        @(negedge clk);
        mode    = 2'b01;
        sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
        check("R2 entry strobe ignored", {31'd0, w_valid}, 32'd0);
        strobe();
        check("R2 first symbol after entry", w_i, exp_trn(1'b0, 3'd1, 3'd2, 0));
        set_mode(2'b00);

        // R6: default data weights
        set_mode(2'b10);
        strobe();
        check("R6 default valid", {31'd0, w_valid}, 32'd1);
        check("R6 default I", w_i, 32'h40404040);
        check("R6 default Q", w_q, 32'd0);

        // R9: idle ignores strobes and holds outputs
        load_opt(2'd1, 8'h7F, 8'h81);
        set_mode(2'b01);
        set_mode(2'b00);
        held = w_i;
        strobe();
        check("R9 idle no valid", {31'd0, w_valid}, 32'd0);
        check("R9 idle holds I", w_i, held);
        strobe();
        check("R9 idle holds Q", w_q, 32'd0);

        // R7: direct optimal write outside training
        load_opt(2'd2, 8'h11, 8'hEE);
        set_mode(2'b11);
        strobe();
        check("R7 opt I", w_i, 32'h4011_7F40);
        check("R7 opt Q", w_q, 32'h00EE_8100);

        // R8: write during training applied after the last symbol
        is_tx = 1'b0;
        n_tx  = 3'd1;
        n_rx  = 3'd2;
        set_mode(2'b01);
        load_opt(2'd1, 8'h22, 8'h33);
        strobe();
        strobe();
        set_mode(2'b11);
        strobe();
        check("R8 deferred after completion I", w_i, 32'h4011_2240);
        check("R8 deferred after completion Q", w_q, 32'h00EE_3300);

        // R8: write during an aborted frame, strobe right after leaving
        n_tx = 3'd4;
        n_rx = 3'd4;
        set_mode(2'b01);
        load_opt(2'd0, 8'h55, 8'h66);
        strobe();
        check("R8 training still running", w_i, exp_trn(1'b0, 3'd4, 3'd4, 0));
        set_mode(2'b11);
        strobe();
        check("R8 deferred after abort I", w_i, 32'h4011_2255);
        check("R8 deferred after abort Q", w_q, 32'h00EE_3366);
        strobe();
        check("R8 committed value kept", w_i, 32'h4011_2255);
        set_mode(2'b00);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule